// File: doc/BRIEF.md
# OTG Sideband Event Interrupt Controller

This block gathers sideband events around a USB OTG port and reports them to a host processor through a small synchronous 32-bit register port. Four PHY control lines (VBUS drive, VBUS charge, VBUS discharge and ID pull-up) arrive asynchronously. Each line passes through a synchronizer, and a rising or a falling edge on it sets its own sticky status bit. An OTG event pulse and the clearing of a DMA-disable configuration bit set two more bits. These ten events form the misc group. A second, core group latches one core interrupt line.

Each group has a raw status view, a masked status view, an enable mask that is changed only through separate set and clear addresses, and a level interrupt output. Software reads a status register, services the events, and writes the same value back to acknowledge them.

Top module: `otg_evt_irq`

## Requirements
- R1: A rising edge on `phy_ctl[3]`, `[2]`, `[1]` or `[0]` (drive, charge, discharge, ID pull-up) sets misc bit 13, 12, 11 or 8 respectively. The bit becomes visible in the register read after the third rising clock edge that follows the input change (two synchronizer stages, then the status register).
- R2: A falling edge on `phy_ctl[3]`, `[2]`, `[1]` or `[0]` sets misc bit 5, 4, 3 or 0 respectively, with the same latency as R1.
- R3: `otg_evt` high at a clock edge sets misc bit 16 at that edge.
- R4: Address 0 is a configuration register whose only storage is bit 16 (the DMA-disable flag); it reads back with all other bits 0. A write that changes that bit from 1 to 0 sets misc bit 17. A write that leaves the bit at 0 or sets it to 1 does not.
- R5: `core_irq` high at a clock edge sets core bit 0 at that edge.
- R6: A write to a raw-status address (1 for misc, 5 for core) or a masked-status address (2, 6) clears every raw bit written as 1 and leaves bits written as 0 unchanged. A write of all zeros changes nothing.
- R7: A write to the enable-set address (3 for misc, 7 for core) turns on the enables for the bits written as 1. A write to the enable-clear address (4, 8) turns off the enables for the bits written as 1. Reading either address returns the enable mask, which holds only implemented bits (misc 0x00033939, core 0x1).
- R8: Raw status (addresses 1 and 5) shows every latched event whatever the enables are. Masked status (addresses 2 and 6) reads raw AND enable.
- R9: `irq_misc` and `irq_core` are high exactly when their group has at least one bit that is both pending and enabled, and they stay high until every such bit is cleared or disabled.
- R10: If an event sets a bit in the same cycle that a write clears it, the bit stays set.
- R11: After reset all status, enables, the configuration flag and both outputs are 0. With the PHY lines low, no event appears after reset. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr | input | 1 | Register write strobe |
| addr | input | AW | Word address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| phy_ctl | input | 4 | Asynchronous PHY control lines: 3 drive, 2 charge, 1 discharge, 0 ID pull-up |
| otg_evt | input | 1 | Synchronous OTG event pulse |
| core_irq | input | 1 | Synchronous core interrupt line |
| irq_misc | output | 1 | Misc group interrupt, level |
| irq_core | output | 1 | Core group interrupt, level |

## Verification
The bench builds the block with its defaults, AW = 4 and SYNC = 2. This makes the three-edge latency of a PHY edge a fixed number that the reference model reproduces from its own sample history. Four address bits also leave room for unmapped addresses that must read 0. Because the model is compared on every cycle, the exact cycle in which each rise and fall bit appears is checked. The same comparison covers the collisions between an event and a clear write, and the DMA-flag transitions that must not raise an event.

// File: rtl/otg_evt_irq.sv
module otg_evt_irq #(
  parameter int AW   = 4,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic [3:0]    phy_ctl,
  input  logic          otg_evt,
  input  logic          core_irq,
  output logic          irq_misc,
  output logic          irq_core
);
  localparam logic [31:0] MISC_MASK = 32'h0003_3939;
  localparam logic [AW-1:0] A_SYS  = AW'(0);
  localparam logic [AW-1:0] A_MRAW = AW'(1);
  localparam logic [AW-1:0] A_MST  = AW'(2);
  localparam logic [AW-1:0] A_MSET = AW'(3);
  localparam logic [AW-1:0] A_MCLR = AW'(4);
  localparam logic [AW-1:0] A_CRAW = AW'(5);
  localparam logic [AW-1:0] A_CST  = AW'(6);
  localparam logic [AW-1:0] A_CSET = AW'(7);
  localparam logic [AW-1:0] A_CCLR = AW'(8);

  logic [3:0]  sh [SYNC];
  logic [3:0]  prev;
  logic        dma_dis;
  logic [31:0] misc_raw, misc_en;
  logic        core_raw, core_en;

  logic [3:0]  cur, rise, fall;
  logic        dma_clr_ev;
  logic [31:0] misc_ev, misc_clr;
  logic        core_clr;

  assign cur  = sh[SYNC-1];
  assign rise = cur & ~prev;
  assign fall = prev & ~cur;
  assign dma_clr_ev = wr && addr == A_SYS && dma_dis && !wdata[16];

  always_comb begin
    misc_ev     = '0;
    misc_ev[13] = rise[3];
    misc_ev[12] = rise[2];
    misc_ev[11] = rise[1];
    misc_ev[8]  = rise[0];
    misc_ev[5]  = fall[3];
    misc_ev[4]  = fall[2];
    misc_ev[3]  = fall[1];
    misc_ev[0]  = fall[0];
    misc_ev[16] = otg_evt;
    misc_ev[17] = dma_clr_ev;
  end

  assign misc_clr = (wr && (addr == A_MRAW || addr == A_MST)) ? wdata : '0;
  assign core_clr = wr && (addr == A_CRAW || addr == A_CST) && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) sh[i] <= '0;
      prev     <= '0;
      dma_dis  <= 1'b0;
      misc_raw <= '0;
      misc_en  <= '0;
      core_raw <= 1'b0;
      core_en  <= 1'b0;
    end else begin
      sh[0] <= phy_ctl;
      for (int i = 1; i < SYNC; i++) sh[i] <= sh[i-1];
      prev     <= cur;
      misc_raw <= (misc_raw & ~misc_clr) | misc_ev;
      core_raw <= (core_raw & ~core_clr) | core_irq;
      if (wr) begin
        case (addr)
          A_SYS:  dma_dis <= wdata[16];
          A_MSET: misc_en <= misc_en | (wdata & MISC_MASK);
          A_MCLR: misc_en <= misc_en & ~wdata;
          A_CSET: core_en <= core_en | wdata[0];
          A_CCLR: core_en <= core_en & ~wdata[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      A_SYS:          rdata = {15'b0, dma_dis, 16'b0};
      A_MRAW:         rdata = misc_raw;
      A_MST:          rdata = misc_raw & misc_en;
      A_MSET, A_MCLR: rdata = misc_en;
      A_CRAW:         rdata = {31'b0, core_raw};
      A_CST:          rdata = {31'b0, core_raw & core_en};
      A_CSET, A_CCLR: rdata = {31'b0, core_en};
      default:        rdata = '0;
    endcase
  end

  assign irq_misc = |(misc_raw & misc_en);
  assign irq_core = core_raw & core_en;
endmodule

module otg_evt_irq_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr,
  input logic [AW-1:0] addr,
  input logic          otg_evt,
  input logic          core_irq,
  input logic [31:0]   misc_raw,
  input logic [31:0]   misc_en,
  input logic          core_raw,
  input logic          irq_misc,
  input logic          irq_core
);
  AST_OTG_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(otg_evt)) |-> misc_raw[16]); // R3
  AST_CORE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(core_irq)) |-> core_raw); // R5
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (($past(misc_raw) & ~misc_raw) != 0))
      |-> $past(wr && (addr == AW'(1) || addr == AW'(2)))); // R6
  AST_SET_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr && addr == AW'(3)))
      |-> (($past(misc_en) & ~misc_en) == 0)); // R7
  AST_IRQ_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_misc |-> (misc_en != 0 && misc_raw != 0)); // R9
  AST_CORE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_core |-> core_raw); // R9
endmodule

bind otg_evt_irq otg_evt_irq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .otg_evt(otg_evt),
  .core_irq(core_irq), .misc_raw(misc_raw), .misc_en(misc_en),
  .core_raw(core_raw), .irq_misc(irq_misc), .irq_core(irq_core)
);

// File: tb/otg_evt_irq_tb.sv
module otg_evt_irq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam logic [31:0] MASK = 32'h0003_3939;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [3:0]    phy_ctl = '0;
  logic          otg_evt = 1'b0;
  logic          core_irq = 1'b0;
  logic          irq_misc, irq_core;

  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;

  otg_evt_irq #(.AW(AW), .SYNC(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .phy_ctl(phy_ctl), .otg_evt(otg_evt),
    .core_irq(core_irq), .irq_misc(irq_misc), .irq_core(irq_core)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  logic [3:0]  hist [$];
  logic [31:0] m_mraw, m_men;
  bit          m_craw, m_cen, m_dma;
  int          rpos [4] = '{8, 11, 12, 13};
  int          fpos [4] = '{0, 3, 4, 5};

  initial begin
    hist = '{4'h0, 4'h0, 4'h0};
    m_mraw = '0; m_men = '0; m_craw = 0; m_cen = 0; m_dma = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{4'h0, 4'h0, 4'h0};
      m_mraw = '0; m_men = '0; m_craw = 0; m_cen = 0; m_dma = 0;
    end else begin
      logic [31:0] ev, clr;
      logic [3:0]  nw, od;
      bit          cclr;
      hist.push_back(phy_ctl);
      nw = hist[hist.size()-3];
      od = hist[hist.size()-4];
      void'(hist.pop_front());
      ev = '0;
      for (int i = 0; i < 4; i++) begin
        if (nw[i] && !od[i]) ev[rpos[i]] = 1'b1;
        if (!nw[i] && od[i]) ev[fpos[i]] = 1'b1;
      end
      if (otg_evt) ev[16] = 1'b1;
      if (wr && addr == 0 && m_dma && !wdata[16]) ev[17] = 1'b1;
      clr  = (wr && (addr == 1 || addr == 2)) ? wdata : 32'h0;
      cclr = wr && (addr == 5 || addr == 6) && wdata[0];
      m_mraw = (m_mraw & ~clr) | ev;
      m_craw = (m_craw && !cclr) || core_irq;
      if (wr) begin
        case (addr)
          0: m_dma = wdata[16];
          3: m_men = m_men | (wdata & MASK);
          4: m_men = m_men & ~wdata;
          7: m_cen = m_cen | wdata[0];
          8: m_cen = m_cen & ~wdata[0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] model_rd(logic [AW-1:0] a);
    case (a)
      0: return {15'b0, m_dma, 16'b0};
      1: return m_mraw;
      2: return m_mraw & m_men;
      3, 4: return m_men;
      5: return {31'b0, m_craw};
      6: return {31'b0, m_craw & m_cen};
      7, 8: return {31'b0, m_cen};
      default: return 32'h0;
    endcase
  endfunction

  task automatic step(string tag, bit w, logic [AW-1:0] a, logic [31:0] d,
                      bit o, bit c);
    logic [31:0] exp_rd;
    bit exp_im, exp_ic;
    wr = w; addr = a; wdata = d; otg_evt = o; core_irq = c;
    @(posedge clk);
    @(negedge clk);
    exp_rd = model_rd(addr);
    exp_im = |(m_mraw & m_men);
    exp_ic = m_craw & m_cen;
    vectors++;
    if (rdata !== exp_rd || irq_misc !== exp_im || irq_core !== exp_ic) begin
      errors++;
      $display("FAIL %s addr=%0d rdata=%h irq_misc=%b irq_core=%b expected rdata=%h irq_misc=%b irq_core=%b",
               tag, addr, rdata, irq_misc, irq_core, exp_rd, exp_im, exp_ic);
    end
  endtask

  task automatic idle(string tag, logic [AW-1:0] a, int n);
    for (int i = 0; i < n; i++) step(tag, 0, a, 32'h0, 0, 0);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    @(negedge clk);
    idle("R11", 0, 3);
    rst_n = 1'b1;
    idle("R11", 1, 4);
    idle("R11", 12, 1);

    // R7 enable set / clear
    step("R7", 1, 3, 32'hFFFF_FFFF, 0, 0);
    idle("R7", 3, 1);
    step("R7", 1, 4, 32'h0000_0100, 0, 0);
    idle("R7", 4, 1);
    step("R7", 1, 3, 32'h0, 0, 0);
    idle("R7", 3, 1);
    step("R7", 1, 3, 32'h0000_0100, 0, 0);

    // R1 rising edges one line at a time
    phy_ctl = 4'b0001; idle("R1", 1, 4);
    phy_ctl = 4'b0011; idle("R1", 1, 4);
    phy_ctl = 4'b0111; idle("R1", 1, 4);
    phy_ctl = 4'b1111; idle("R1", 1, 4);
    step("R6", 1, 1, 32'h0000_3900, 0, 0);
    idle("R6", 1, 1);

    // R2 falling edges, all together
    phy_ctl = 4'b0000; idle("R2", 1, 4);
    step("R6", 1, 2, 32'h0000_0039, 0, 0);
    idle("R9", 2, 1);

    // R3 otg event; R6 zero write leaves it
    step("R3", 0, 1, 32'h0, 1, 0);
    idle("R3", 1, 2);
    step("R6", 1, 1, 32'h0, 0, 0);
    idle("R6", 1, 1);
    step("R6", 1, 1, 32'h0001_0000, 0, 0);

    // R4 dma-disable flag transitions
    step("R4", 1, 0, 32'h0001_0000, 0, 0);
    step("R4", 1, 0, 32'hFFFF_FFFF, 0, 0);
    idle("R4", 1, 1);
    step("R4", 1, 0, 32'h0, 0, 0);
    idle("R4", 1, 1);
    step("R4", 1, 0, 32'h0, 0, 0);
    idle("R4", 0, 1);
    step("R4", 1, 1, 32'h0002_0000, 0, 0);
    idle("R4", 1, 1);

    // R8 / R9 masking
    step("R8", 1, 4, 32'h0003_0000, 0, 0);
    step("R8", 0, 2, 32'h0, 1, 0);
    idle("R8", 2, 1);
    idle("R8", 1, 1);
    step("R9", 1, 3, 32'h0001_0000, 0, 0);
    idle("R9", 2, 1);

    // R10 event beats clear in the same cycle
    step("R10", 1, 1, 32'h0001_0000, 1, 0);
    idle("R10", 1, 1);
    step("R10", 1, 1, 32'h0001_0000, 0, 0);
    idle("R9", 1, 1);

    // R5 core group
    step("R5", 0, 5, 32'h0, 0, 1);
    idle("R5", 6, 1);
    step("R5", 1, 7, 32'h1, 0, 0);
    idle("R5", 6, 1);
    step("R10", 1, 5, 32'h1, 0, 1);
    idle("R10", 5, 1);
    step("R6", 1, 6, 32'h1, 0, 0);
    idle("R9", 6, 1);
    step("R5", 0, 5, 32'h0, 0, 1);
    step("R7", 1, 8, 32'h1, 0, 0);
    idle("R7", 7, 1);
    idle("R8", 5, 1);
    idle("R11", 15, 1);

    finish_up();
  end
endmodule